// File: doc/BRIEF.md
# Comparator Pin and Event Control

This block is the digital side of an on-chip voltage comparator. Software writes a six-bit control word that turns the comparator on, hands the output pin to it, picks the edge direction for events, and picks the source of the positive input. From that word the block derives per-pin ownership selects for the three shared pins: the negative input, the positive input and the output. It also derives a three-bit code for the reference ladder. The analog comparator and the ladder sit outside the block. They appear here only as the asynchronous result input `cmp_raw_i` and the `ref_code_o` output.

The raw result passes through a two-flop synchronizer. The synchronized value is shown unlatched as a live status bit. An edge detector watches the same value and sets a sticky event flag on the selected transition. Software reads the control word and both status bits back through one read port. It clears the event flag with a strobe.

Top module: `cmp_ctrl`

## Requirements
- R1: While the enable field is 0, `neg_sel_o`, `pos_sel_o` and `out_sel_o` are 0 (all pins are general-purpose I/O), `ref_code_o` is 000, and both the live status bit and `cmp_out_o` read 0.
- R2: While the enable field is 1, `neg_sel_o` is 1.
- R3: While enabled, a source-select field of 000 gives `pos_sel_o`=1 and `ref_code_o`=000. Any value from 001 to 111 gives `pos_sel_o`=0 and puts that value on `ref_code_o`, selecting an internal level between 0.2·Vdd and 0.8·Vdd in steps of 0.1·Vdd.
- R4: While enabled with the pin-drive field at 1, `out_sel_o` is 1 and `cmp_out_o` equals the live result. With the field at 0, `out_sel_o` and `cmp_out_o` are 0.
- R5: While enabled, the live status bit (read bit 6) equals `cmp_raw_i` as sampled two clock edges earlier. It is never latched.
- R6: The event flag (read bit 7, also `irq_o`) sets one edge after the synchronized result goes 0→1 when the edge field is 1, or 1→0 when the edge field is 0.
- R7: Once set, the event flag stays set until a `flag_clr_i` strobe is sampled.
- R8: If a clear strobe and a qualifying transition are seen on the same edge, the flag ends up set.
- R9: The flag does not set from a level already present when the block is enabled, nor on the edge that writes a new edge-direction value.
- R10: Control write data takes enable at bit 0, pin drive at bit 1, edge direction at bit 2 and source select at bits 5:3. Read data returns those six bits unchanged, with the live bit at bit 6 and the event flag at bit 7.
- R11: After reset, the control word, the synchronizer and the event flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 8 | Control write data (bits 7:6 ignored) |
| flag_clr_i | input | 1 | Event flag clear strobe |
| cmp_raw_i | input | 1 | Asynchronous comparator result |
| rdata_o | output | 8 | Read data: flag, live bit, control word |
| neg_sel_o | output | 1 | Negative-input pin owned by comparator |
| pos_sel_o | output | 1 | Positive-input pin owned by comparator |
| out_sel_o | output | 1 | Output pin driven by comparator |
| ref_code_o | output | 3 | Reference ladder select code |
| cmp_out_o | output | 1 | Value driven onto the output pin |
| irq_o | output | 1 | Event flag |

## Verification
The result input is driven with slow square waves under both edge directions. This separates rising detection from falling detection and checks that the flag stays set across later opposite edges. Directed cases enable the block while the result is already high, and write a new edge direction on the cycle a transition arrives. These tell a correctly primed edge detector from one that raises a false event. A clear strobe held across a transition separates set-wins priority from clear-wins priority. A long stretch of random control writes, clears and result toggles then checks the pin selects and reference code for every source-select value. The bench compares against a queue-based reference on every clock.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;
  localparam int unsigned REF_W  = 3;
  localparam int unsigned CTRL_W = 3 + REF_W;
  localparam int unsigned DATA_W = CTRL_W + 2;

  typedef struct packed {
    logic [REF_W-1:0] src_sel;  // 0: external pin, else internal level
    logic             edge_rise;
    logic             pin_drv;
    logic             enable;
  } ctrl_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux
  import cmp_ctrl_pkg::*;
(
  input  ctrl_t            ctrl_i,
  input  logic             live_i,
  output logic             neg_sel_o,
  output logic             pos_sel_o,
  output logic             out_sel_o,
  output logic [REF_W-1:0] ref_code_o,
  output logic             cmp_out_o
);
  logic ext_src;

  always_comb begin
    ext_src    = (ctrl_i.src_sel == '0);
    neg_sel_o  = ctrl_i.enable;
    pos_sel_o  = ctrl_i.enable & ext_src;
    out_sel_o  = ctrl_i.enable & ctrl_i.pin_drv;
    ref_code_o = ctrl_i.enable ? ctrl_i.src_sel : '0;
    cmp_out_o  = out_sel_o & live_i;
  end
endmodule

// File: rtl/cmp_edge_flag.sv
module cmp_edge_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic edge_rise_i,
  input  logic dir_chg_i,
  input  logic level_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q, flag_q, hit;

  // prev tracks level every cycle, so enabling or flipping direction is primed
  always_comb
    hit = enable_i & ~dir_chg_i & (prev_q != level_i) & (level_i == edge_rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      if (hit)        flag_q <= 1'b1;  // set beats clear
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
  import cmp_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] ctrl_wdata_i,
  input  logic              flag_clr_i,
  input  logic              cmp_raw_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              neg_sel_o,
  output logic              pos_sel_o,
  output logic              out_sel_o,
  output logic [REF_W-1:0]  ref_code_o,
  output logic              cmp_out_o,
  output logic              irq_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  sync_lvl, live, dir_chg, flag;

  assign ctrl_d  = ctrl_t'(ctrl_wdata_i[CTRL_W-1:0]);
  assign dir_chg = ctrl_we_i & (ctrl_d.edge_rise != ctrl_q.edge_rise);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_d;

  cmp_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_raw_i),
    .q_o   (sync_lvl)
  );

  assign live = ctrl_q.enable & sync_lvl;

  cmp_edge_flag i_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (ctrl_q.enable),
    .edge_rise_i(ctrl_q.edge_rise),
    .dir_chg_i  (dir_chg),
    .level_i    (sync_lvl),
    .clr_i      (flag_clr_i),
    .flag_o     (flag)
  );

  cmp_pin_mux i_mux (
    .ctrl_i    (ctrl_q),
    .live_i    (live),
    .neg_sel_o (neg_sel_o),
    .pos_sel_o (pos_sel_o),
    .out_sel_o (out_sel_o),
    .ref_code_o(ref_code_o),
    .cmp_out_o (cmp_out_o)
  );

  assign rdata_o = {flag, live, ctrl_q};
  assign irq_o   = flag;
endmodule

// File: rtl/cmp_ctrl_chk.sv
module cmp_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       flag_clr_i,
  input logic [7:0] rdata_o,
  input logic       neg_sel_o,
  input logic       pos_sel_o,
  input logic       out_sel_o,
  input logic [2:0] ref_code_o,
  input logic       cmp_out_o,
  input logic       irq_o
);
  // R1
  gpio_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[0] |-> (!neg_sel_o && !pos_sel_o && !out_sel_o && ref_code_o == 3'b000 && !cmp_out_o));
  // R2
  neg_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[0] |-> neg_sel_o);
  // R3
  src_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_sel_o && ref_code_o != 3'b000));
  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !flag_clr_i) |=> irq_o);
  // R7
  flag_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(flag_clr_i));
  // R6
  flag_set_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(rdata_o[0]));
endmodule

bind cmp_ctrl cmp_ctrl_chk i_cmp_ctrl_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .flag_clr_i(flag_clr_i),
  .rdata_o   (rdata_o),
  .neg_sel_o (neg_sel_o),
  .pos_sel_o (pos_sel_o),
  .out_sel_o (out_sel_o),
  .ref_code_o(ref_code_o),
  .cmp_out_o (cmp_out_o),
  .irq_o     (irq_o)
);

// File: tb/test_cmp_ctrl.sv
`timescale 1ns/1ps
module test_cmp_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wd = '0;
  logic       clr = 1'b0;
  logic       raw = 1'b0;
  logic [7:0] rdata;
  logic       neg_sel, pos_sel, out_sel, cmp_out, irq;
  logic [2:0] ref_code;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  cmp_ctrl i_cmp_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wd),
    .flag_clr_i(clr), .cmp_raw_i(raw), .rdata_o(rdata),
    .neg_sel_o(neg_sel), .pos_sel_o(pos_sel), .out_sel_o(out_sel),
    .ref_code_o(ref_code), .cmp_out_o(cmp_out), .irq_o(irq)
  );

  // reference model state
  bit       m_en, m_drv, m_rise, m_flag;
  bit [2:0] m_src;
  bit       m_prev;
  bit       hist[$] = '{1'b0, 1'b0};  // oldest first: value seen by status

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_drv = 0; m_rise = 0; m_flag = 0; m_src = 0; m_prev = 0;
      hist = '{1'b0, 1'b0};
    end else begin
      bit lvl, chg, hit;
      lvl = hist[0];
      chg = we && (wd[2] != m_rise);
      hit = m_en && !chg && (lvl != m_prev) && (lvl == m_rise);
      if (hit) m_flag = 1;
      else if (clr) m_flag = 0;
      m_prev = lvl;
      void'(hist.pop_front());
      hist.push_back(raw);
      if (we) begin
        m_en = wd[0]; m_drv = wd[1]; m_rise = wd[2]; m_src = wd[5:3];
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    bit live;
    live = m_en && hist[0];
    check("R11/R1 neg_sel", neg_sel, m_en);
    check("R2 neg_sel", neg_sel, m_en);
    check("R3 pos_sel", pos_sel, m_en && m_src == 0);
    check("R3 ref_code", ref_code, m_en ? m_src : 0);
    check("R4 out_sel", out_sel, m_en && m_drv);
    check("R4 cmp_out", cmp_out, m_en && m_drv && live);
    check("R5 live", rdata[6], live);
    check("R6/R7/R8/R9 flag", rdata[7], m_flag);
    check("R6 irq", irq, m_flag);
    check("R10 ctrl echo", rdata[5:0], {m_src, m_rise, m_drv, m_en});
  end

  task automatic step(bit w, bit [7:0] d, bit c, bit r);
    @(negedge clk);
    we = w; wd = d; clr = c; raw = r;
  endtask

  task automatic hold(int n, bit r);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, r);
  endtask

  function automatic bit [7:0] cw(bit en, bit drv, bit rise, bit [2:0] src);
    return {2'b11, src, rise, drv, en};  // upper bits must be ignored (R10)
  endfunction

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: disabled, toggling result
    hold(4, 1); hold(4, 0); hold(4, 1);
    // R9: enable while result already high, rising edge selected
    step(1, cw(1, 1, 1, 3'd0), 0, 1); hold(6, 1);
    // R6 rising, R7 hold across falls
    hold(5, 0); hold(5, 1); hold(5, 0); hold(5, 1);
    step(0, 8'h00, 1, 1); hold(4, 1);
    // R3 internal level, R4 pin drive off
    step(1, cw(1, 0, 1, 3'd5), 0, 1); hold(3, 1);
    // R9: direction flip to falling while high, then falling edge R6
    step(1, cw(1, 0, 0, 3'd5), 0, 1); hold(4, 1); hold(5, 0);
    // R8: clear held across a falling transition
    step(0, 8'h00, 1, 0); hold(3, 1);
    for (int i = 0; i < 6; i++) step(0, 8'h00, 1, (i < 2));
    hold(4, 0);
    // R9: direction write on the cycle a transition reaches the detector
    hold(4, 1); hold(1, 0); hold(1, 0);
    step(1, cw(1, 1, 1, 3'd0), 0, 0); hold(4, 0);
    hold(2, 1); step(1, cw(1, 1, 0, 3'd0), 0, 0); hold(4, 0);
    // R1: disable with flag set, then clear
    step(1, cw(0, 1, 1, 3'd7), 0, 1); hold(4, 0); step(0, 8'h00, 1, 0); hold(2, 0);
    // all source codes
    for (int s = 0; s < 8; s++) begin
      step(1, cw(1, s[0], s[1], 3'(s)), 0, s[0]); hold(3, s[1]);
    end
    // random stretch
    for (int i = 0; i < 2000; i++) begin
      bit [31:0] r;
      r = $urandom;
      step(r[3:0] == 0, r[15:8], r[7:5] == 0, r[20]);
    end
    hold(4, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule